// File: doc/BRIEF.md
# Execute-Stage Exception Trap Controller

This block sits at the execute stage of a simple in-order pipeline. For each instruction there, it decides whether the instruction takes an undefined-instruction trap or a breakpoint trap. A breakpoint is treated like a prefetch abort. The decode stage supplies classification flags for each instruction: undefined encoding, floating-point coprocessor op, integer divide, and breakpoint. It also supplies the divisor operand and the instruction address. Two control bits complete the inputs: one enables the floating-point unit, and one makes a zero divisor trap.

When a trap is taken, the block raises a one-cycle request together with a trap kind, a link value, an IRQ-mask update and a redirect to the matching vector address. All of these are registered, so they appear one cycle after the instruction was presented. A breakpoint acts only when it reaches execute. Any instruction flushed in that cycle, for example by a taken branch ahead of it, has no effect. After a trap, the block ignores instructions for a fixed number of cycles while the redirect takes effect.

Top module: `exc_trap_unit`

## Requirements
- R1: A valid, unflushed instruction flagged as an undefined encoding yields a trap request of kind 1 (undefined) with redirect address UNDEF_VEC.
- R2: A floating-point coprocessor op traps as kind 1 when the floating-point enable input is 0, and raises no trap when it is 1.
- R3: An integer divide with an all-zero divisor traps as kind 1 only when the divide-by-zero enable input is 1. A non-zero divisor, or the enable at 0, gives no trap.
- R4: Every undefined-instruction trap drives the IRQ-mask update output high in the same cycle as the trap request.
- R5: A breakpoint op yields a trap of kind 2 (prefetch abort) with redirect address PABT_VEC. Its link value equals the instruction address plus 4, so link minus 4 re-executes the breakpoint.
- R6: An instruction presented with flush high raises no trap, whatever its flags.
- R7: When a breakpoint and any undefined condition occur on the same instruction, the breakpoint trap (kind 2) wins.
- R8: The trap request is high for exactly one cycle, one clock after the instruction is sampled. Redirect valid and redirect address are driven in that same cycle.
- R9: For BLANK_CYC clock cycles after a trap is accepted, incoming instructions are ignored. The instruction in the cycle that follows is evaluated again.
- R10: An undefined-instruction trap returns a link value equal to the instruction address plus 4.
- R11: While in reset and just after it, trap request and redirect valid are 0 and the trap kind is 0 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | An instruction occupies execute |
| dec_undef | input | 1 | Encoding decodes as undefined |
| dec_fp_op | input | 1 | Floating-point coprocessor op |
| dec_div_op | input | 1 | Signed or unsigned divide |
| dec_bkpt | input | 1 | Breakpoint op |
| divisor | input | DW | Divisor operand value |
| fp_enable | input | 1 | Floating-point unit enabled |
| dz_trap_en | input | 1 | Trap on divide by zero |
| flush | input | 1 | Squash instruction in execute |
| ex_pc | input | AW | Address of the instruction in execute |
| trap_req | output | 1 | One-cycle trap request |
| trap_kind | output | 2 | 0 none, 1 undefined, 2 prefetch abort |
| link_val | output | AW | Link register value for the handler |
| irq_mask_set | output | 1 | Set the IRQ disable mask |
| redirect_vld | output | 1 | Fetch redirect strobe |
| redirect_addr | output | AW | Vector address for the redirect |

## Verification
A breakpoint and an undefined condition can land on the same instruction, and so can a flush and either kind of trap. The bench provokes these overlaps with directed cases and also lets random flags pile up on one instruction. A reference function then decides the result in the order flush, then breakpoint, then undefined. Each cycle's kind, vector and link are compared with that decision. The bench also keeps its own model of the blanking window, so it can tell which overlapping instructions should have been ignored.

// File: rtl/exc_trap_pkg.sv
package exc_trap_pkg;
  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_UNDEF = 2'd1,
    TK_PABT  = 2'd2
  } trap_kind_e;
endpackage

// File: rtl/exc_trap_detect.sv
// Classifies the execute-stage instruction into trap conditions.
module exc_trap_detect #(
  parameter int DW = 32
) (
  input  logic          dec_undef,
  input  logic          dec_fp_op,
  input  logic          dec_div_op,
  input  logic          dec_bkpt,
  input  logic [DW-1:0] divisor,
  input  logic          fp_enable,
  input  logic          dz_trap_en,
  output logic          undef_hit,
  output logic          bkpt_hit
);
  logic div_zero;
  logic fp_off_hit;
  logic dz_hit;

  always_comb begin
    div_zero   = ~|divisor;
    fp_off_hit = dec_fp_op & ~fp_enable;
    dz_hit     = dec_div_op & div_zero & dz_trap_en;
    undef_hit  = dec_undef | fp_off_hit | dz_hit;
    bkpt_hit   = dec_bkpt;
  end
endmodule

// File: rtl/exc_trap_arb.sv
// Fixed priority: flush, then breakpoint, then undefined.
module exc_trap_arb
  import exc_trap_pkg::*;
(
  input  logic       ex_valid,
  input  logic       busy,
  input  logic       flush,
  input  logic       undef_hit,
  input  logic       bkpt_hit,
  output logic       take,
  output trap_kind_e kind
);
  logic live;

  always_comb begin
    live = ex_valid & ~busy & ~flush;
    kind = TK_NONE;
    if (live && bkpt_hit)       kind = TK_PABT;
    else if (live && undef_hit) kind = TK_UNDEF;
    take = (kind != TK_NONE);
  end
endmodule

// File: rtl/exc_trap_gate.sv
// Blanking window that holds off new instructions after a trap.
module exc_trap_gate #(
  parameter int BLANK_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  output logic busy
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOADV = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (take)              cnt_d = LOADV;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/exc_trap_unit.sv
module exc_trap_unit
  import exc_trap_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          BLANK_CYC = 2,
  parameter int          RET_OFS   = 4,
  parameter logic [31:0] UNDEF_VEC = 32'h0000_0004,
  parameter logic [31:0] PABT_VEC  = 32'h0000_000C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_valid,
  input  logic          dec_undef,
  input  logic          dec_fp_op,
  input  logic          dec_div_op,
  input  logic          dec_bkpt,
  input  logic [DW-1:0] divisor,
  input  logic          fp_enable,
  input  logic          dz_trap_en,
  input  logic          flush,
  input  logic [AW-1:0] ex_pc,
  output logic          trap_req,
  output logic [1:0]    trap_kind,
  output logic [AW-1:0] link_val,
  output logic          irq_mask_set,
  output logic          redirect_vld,
  output logic [AW-1:0] redirect_addr
);
  localparam logic [AW-1:0] OFS   = AW'(RET_OFS);
  localparam logic [AW-1:0] V_UND = AW'(UNDEF_VEC);
  localparam logic [AW-1:0] V_PAB = AW'(PABT_VEC);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic       undef_hit, bkpt_hit, busy, take;
  trap_kind_e kind;

  exc_trap_detect #(.DW(DW)) u_det (
    .dec_undef (dec_undef),
    .dec_fp_op (dec_fp_op),
    .dec_div_op(dec_div_op),
    .dec_bkpt  (dec_bkpt),
    .divisor   (divisor),
    .fp_enable (fp_enable),
    .dz_trap_en(dz_trap_en),
    .undef_hit (undef_hit),
    .bkpt_hit  (bkpt_hit)
  );

  exc_trap_arb u_arb (
    .ex_valid (ex_valid),
    .busy     (busy),
    .flush    (flush),
    .undef_hit(undef_hit),
    .bkpt_hit (bkpt_hit),
    .take     (take),
    .kind     (kind)
  );

  exc_trap_gate #(.BLANK_CYC(BLANK_CYC)) u_gate (
    .clk  (clk),
    .rst_n(rst_core_n),
    .take (take),
    .busy (busy)
  );

  // next-state
  logic          req_d;
  logic [1:0]    kind_d;
  logic [AW-1:0] link_d, vec_d;
  logic          link_en;

  always_comb begin
    req_d   = take;
    kind_d  = kind;
    link_en = take;
    link_d  = ex_pc + OFS;
    vec_d   = (kind == TK_PABT) ? V_PAB : V_UND;
  end

  // registers
  logic          req_q;
  logic [1:0]    kind_q;
  logic [AW-1:0] link_q, vec_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      req_q  <= 1'b0;
      kind_q <= 2'd0;
    end else begin
      req_q  <= req_d;
      kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      link_q <= '0;
      vec_q  <= '0;
    end else if (link_en) begin
      link_q <= link_d;
      vec_q  <= vec_d;
    end
  end

  assign trap_req      = req_q;
  assign trap_kind     = kind_q;
  assign link_val      = link_q;
  assign irq_mask_set  = req_q;
  assign redirect_vld  = req_q;
  assign redirect_addr = vec_q;
endmodule

// File: rtl/exc_trap_chk.sv
module exc_trap_chk #(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          RET_OFS   = 4,
  parameter logic [31:0] UNDEF_VEC = 32'h4,
  parameter logic [31:0] PABT_VEC  = 32'hC
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ex_valid,
  input logic          dec_undef,
  input logic          dec_fp_op,
  input logic          dec_div_op,
  input logic          dec_bkpt,
  input logic          fp_enable,
  input logic          flush,
  input logic          dz_trap_en,
  input logic [AW-1:0] ex_pc,
  input logic          trap_req,
  input logic [1:0]    trap_kind,
  input logic [AW-1:0] link_val,
  input logic          irq_mask_set,
  input logic          redirect_vld,
  input logic [AW-1:0] redirect_addr
);
  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && flush) |=> !trap_req);

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req);

  p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> redirect_vld);

  p_irq_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_kind == 2'd1) |-> irq_mask_set);

  p_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_kind == 2'd1) |-> redirect_addr == AW'(UNDEF_VEC));

  p_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_kind == 2'd2) |->
      (link_val == $past(ex_pc) + AW'(RET_OFS) && redirect_addr == AW'(PABT_VEC)));

  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !flush && dec_bkpt) |=> (!trap_req || trap_kind == 2'd2));

  p_dz_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && dec_div_op && !dz_trap_en && !dec_undef && !dec_bkpt &&
     !(dec_fp_op && !fp_enable)) |=> !trap_req);

  p_idle_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> trap_kind == 2'd0);
endmodule

bind exc_trap_unit exc_trap_chk #(
  .AW(AW), .DW(DW), .RET_OFS(RET_OFS), .UNDEF_VEC(UNDEF_VEC), .PABT_VEC(PABT_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .dec_undef(dec_undef),
  .dec_fp_op(dec_fp_op), .dec_div_op(dec_div_op), .dec_bkpt(dec_bkpt),
  .fp_enable(fp_enable), .flush(flush), .dz_trap_en(dz_trap_en), .ex_pc(ex_pc),
  .trap_req(trap_req), .trap_kind(trap_kind), .link_val(link_val),
  .irq_mask_set(irq_mask_set), .redirect_vld(redirect_vld),
  .redirect_addr(redirect_addr)
);

// File: tb/sim_exc_trap_unit.sv
module sim_exc_trap_unit;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BLANK = 2;
  localparam logic [31:0] UV = 32'h0000_0004;
  localparam logic [31:0] PV = 32'h0000_000C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex_valid = 0, dec_undef = 0, dec_fp_op = 0, dec_div_op = 0, dec_bkpt = 0;
  logic [DW-1:0] divisor = '0;
  logic fp_enable = 0, dz_trap_en = 0, flush = 0;
  logic [AW-1:0] ex_pc = '0;
  logic trap_req, irq_mask_set, redirect_vld;
  logic [1:0] trap_kind;
  logic [AW-1:0] link_val, redirect_addr;

  always #2 clk = ~clk;

  exc_trap_unit #(.AW(AW), .DW(DW), .BLANK_CYC(BLANK), .UNDEF_VEC(UV), .PABT_VEC(PV)) u0 (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .dec_undef(dec_undef),
    .dec_fp_op(dec_fp_op), .dec_div_op(dec_div_op), .dec_bkpt(dec_bkpt),
    .divisor(divisor), .fp_enable(fp_enable), .dz_trap_en(dz_trap_en),
    .flush(flush), .ex_pc(ex_pc), .trap_req(trap_req), .trap_kind(trap_kind),
    .link_val(link_val), .irq_mask_set(irq_mask_set), .redirect_vld(redirect_vld),
    .redirect_addr(redirect_addr)
  );

  int checks = 0;
  int fails = 0;
  int blank_m = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected trap kind from the requirements: 0 none, 1 undefined, 2 prefetch abort
  function automatic int exp_kind();
    bit und;
    if (!ex_valid || flush || blank_m != 0) return 0;
    if (dec_bkpt) return 2;
    und = dec_undef || (dec_fp_op && !fp_enable) ||
          (dec_div_op && divisor == '0 && dz_trap_en);
    return und ? 1 : 0;
  endfunction

  function automatic string tag_of();
    if (ex_valid && flush) return "R6";
    if (ex_valid && blank_m != 0) return "R9";
    if (dec_bkpt && (dec_undef || dec_fp_op || dec_div_op)) return "R7";
    if (dec_bkpt) return "R5";
    if (dec_div_op) return "R3";
    if (dec_fp_op) return "R2";
    return "R1";
  endfunction

  // one instruction cycle: inputs already set at negedge; check after edge
  task automatic step(input string extra);
    int k;
    string t;
    logic [AW-1:0] pc;
    k = exp_kind();
    t = (extra.len() != 0) ? extra : tag_of();
    pc = ex_pc;
    @(posedge clk);
    @(negedge clk);
    chk(trap_req == (k != 0), t, trap_req, k != 0);
    chk(trap_kind == 2'(k), t, trap_kind, k);
    if (k != 0) begin
      chk(redirect_vld == 1'b1, "R8", redirect_vld, 1);
      chk(redirect_addr == ((k == 2) ? PV : UV), (k == 2) ? "R5" : "R1",
          redirect_addr, (k == 2) ? PV : UV);
      chk(link_val == pc + 4, (k == 2) ? "R5" : "R10", link_val, pc + 4);
      if (k == 1) chk(irq_mask_set == 1'b1, "R4", irq_mask_set, 1);
      blank_m = BLANK;
    end else if (blank_m != 0) begin
      blank_m--;
    end
  endtask

  task automatic clr();
    ex_valid = 0; dec_undef = 0; dec_fp_op = 0; dec_div_op = 0; dec_bkpt = 0;
    divisor = 32'd7; fp_enable = 1; dz_trap_en = 0; flush = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin clr(); step("R9"); end
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clr();
    repeat (3) @(negedge clk);
    chk(trap_req == 0 && redirect_vld == 0, "R11", trap_req, 0);
    chk(trap_kind == 0, "R11", trap_kind, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(trap_req == 0 && trap_kind == 0, "R11", trap_kind, 0);

    // R1 undefined encoding
    clr(); ex_valid = 1; dec_undef = 1; ex_pc = 32'h100; step("R1"); idle(3);
    // R2 fp op enabled vs disabled
    clr(); ex_valid = 1; dec_fp_op = 1; fp_enable = 1; ex_pc = 32'h104; step("R2"); idle(1);
    clr(); ex_valid = 1; dec_fp_op = 1; fp_enable = 0; ex_pc = 32'h108; step("R2"); idle(3);
    // R3 divide by zero, enable off / on / nonzero divisor
    clr(); ex_valid = 1; dec_div_op = 1; divisor = 0; dz_trap_en = 0; step("R3"); idle(1);
    clr(); ex_valid = 1; dec_div_op = 1; divisor = 5; dz_trap_en = 1; step("R3"); idle(1);
    clr(); ex_valid = 1; dec_div_op = 1; divisor = 0; dz_trap_en = 1; ex_pc = 32'h10C; step("R3"); idle(3);
    // R5 breakpoint
    clr(); ex_valid = 1; dec_bkpt = 1; ex_pc = 32'h200; step("R5"); idle(3);
    // R7 breakpoint beats undefined
    clr(); ex_valid = 1; dec_bkpt = 1; dec_undef = 1; ex_pc = 32'h204; step("R7"); idle(3);
    // R6 flushed breakpoint / undefined
    clr(); ex_valid = 1; dec_bkpt = 1; flush = 1; step("R6"); idle(1);
    clr(); ex_valid = 1; dec_undef = 1; flush = 1; step("R6"); idle(1);
    // R9 back-to-back: trap, then two ignored, then accepted
    clr(); ex_valid = 1; dec_undef = 1; ex_pc = 32'h300; step("R9");
    clr(); ex_valid = 1; dec_bkpt = 1; ex_pc = 32'h304; step("R9");
    clr(); ex_valid = 1; dec_undef = 1; ex_pc = 32'h308; step("R9");
    clr(); ex_valid = 1; dec_bkpt = 1; ex_pc = 32'h30C; step("R9");
    idle(3);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      ex_valid   = ($urandom % 10) < 7;
      dec_bkpt   = ($urandom % 10) == 0;
      dec_undef  = ($urandom % 100) < 15;
      dec_fp_op  = ($urandom % 5) == 0;
      dec_div_op = ($urandom % 5) == 0;
      divisor    = (($urandom % 10) < 3) ? '0 : $urandom;
      fp_enable  = $urandom % 2;
      dz_trap_en = $urandom % 2;
      flush      = ($urandom % 10) == 0;
      ex_pc      = $urandom & 32'hFFFF_FFFC;
      step("");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule